// File: doc/BRIEF.md
# Instruction Prefix and Length Decoder

This block sits between an instruction fetch buffer and the decode stage of a processor with variable-length instructions. The fetch buffer presents a window of up to ten bytes, in little-endian order with byte 0 the oldest, and a count of how many of those bytes are valid. The block looks at the first byte. If its three low bits are all ones it is a control prefix, and the next byte is the opcode. Otherwise the first byte is the opcode itself and the control fields are taken as zero. The prefix sets the addressing-mode width, the register size and an extension selector.

The opcode is sent out on a lookup port. An external table returns the opcode's operand class: none, immediate, short address or long address. The block uses that class and the control fields to size the operand, gather its bytes and compute the total instruction length. An instruction is accepted only when the window holds every one of its bytes. In that cycle the block pulses a consume strobe together with the byte count, so the fetch buffer can drop those bytes.

The decoded instruction is held in one output register with a valid/ready handshake. While `out_valid_o` is high and `out_ready_i` is low, every output field stays frozen and nothing more is taken from the fetch buffer. The register reloads in the same cycle that the current instruction is taken, so back-to-back instructions can flow at one per clock.

Top module: `instr_prefix_decoder`

## Requirements
- R1: After reset, `out_valid_o` is 0 and `win_consume_o` is 0.
- R2: A first byte whose bits 2:0 are 111 is a prefix. Its bit 3 gives `out_am_o`, bits 5:4 give `out_rsz_o` and bits 7:6 give `out_ext_o`. The following byte is the opcode even when its own low bits are 111.
- R3: When the first byte is not a prefix, that byte is the opcode, `out_am_o`, `out_rsz_o` and `out_ext_o` are all zero, and no prefix byte is counted in the length.
- R4: Operand size is set by the lookup class on `lut_class_i`. Class 0 (none) has 0 bytes. Class 1 (immediate) has 1, 2, 4 or 8 bytes for register size 00, 01, 10 or 11. Class 2 (short address) has 1 byte when the addressing-mode bit is 0 and 4 bytes when it is 1. Class 3 (long address) has 2 bytes when the addressing-mode bit is 0 and 8 bytes when it is 1.
- R5: The length equals the prefix count (0 or 1), plus 1 for the opcode, plus the operand bytes. The length is always between 1 and 10.
- R6: `out_operand_o` takes the operand bytes that follow the opcode, least significant byte first. Bits above the operand size are zero, and bytes beyond the instruction never appear.
- R7: An instruction is accepted only when `win_avail_i` is at least its length. Otherwise `win_consume_o` stays 0 and no new output is produced.
- R8: In the cycle an instruction is accepted, `win_consume_o` is 1 and `win_consume_cnt_o` equals the length. On the next clock `out_valid_o` rises with the decoded fields and `out_len_o` equals that count.
- R9: While `out_valid_o` is 1 and `out_ready_i` is 0, `win_consume_o` is 0 and all output fields hold. When `out_ready_i` goes high, a waiting instruction is accepted in that same cycle.
- R10: `out_illegal_o` is 1 exactly when the extension field is 10 (the unused code). Codes 00, 01 and 11 give 0.
- R11: `lut_opcode_o` shows the opcode byte combinationally: window byte 1 when a prefix is present, byte 0 otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| win_bytes_i | input | 80 | Fetch window; byte k is bits 8k+7:8k, byte 0 oldest |
| win_avail_i | input | 4 | Number of valid bytes in the window (0 to 10) |
| win_consume_o | output | 1 | Pulses when an instruction is taken from the window |
| win_consume_cnt_o | output | 4 | Bytes to drop from the window; zero when not consuming |
| lut_opcode_o | output | 8 | Opcode sent to the external operand-class table |
| lut_class_i | input | 2 | Operand class returned: 0 none, 1 immediate, 2 short address, 3 long address |
| out_valid_o | output | 1 | Decoded instruction is valid |
| out_ready_i | input | 1 | Downstream takes the decoded instruction |
| out_am_o | output | 1 | Addressing-mode bit |
| out_rsz_o | output | 2 | Register size code |
| out_ext_o | output | 2 | Extension selector |
| out_illegal_o | output | 1 | Extension selector holds the unused code |
| out_opcode_o | output | 8 | Opcode byte |
| out_operand_o | output | 64 | Assembled operand, zero-extended |
| out_len_o | output | 4 | Total instruction length in bytes |

## Verification
The consume strobe, the consume count and the lookup opcode are combinational. They follow the window and the count in the same cycle the window is presented. The decoded fields and `out_valid_o` come from one register, so they appear one clock after the accepting cycle. The bench changes inputs just after a falling edge and reads the combinational results 2 ns later. It reads the registered fields at the next falling edge, which is after exactly one rising edge. The stall scenarios read the outputs at several falling edges in a row to confirm that they do not move.

// File: rtl/pd_pkg.sv
package pd_pkg;
  // operand class returned by the external opcode table
  typedef enum logic [1:0] {
    OPC_NONE   = 2'd0,
    OPC_IMM    = 2'd1,
    OPC_ADDR_S = 2'd2,
    OPC_ADDR_L = 2'd3
  } opr_class_e;

  // prefix byte layout; neighbours decode these positions
  localparam logic [2:0] PFX_MARK     = 3'b111;
  localparam int unsigned PFX_AM_BIT  = 3;
  localparam int unsigned PFX_RSZ_LSB = 4;
  localparam int unsigned PFX_EXT_LSB = 6;
  localparam logic [1:0] EXT_UNUSED   = 2'b10;
endpackage

// File: rtl/pd_prefix_split.sv
module pd_prefix_split (
  input  logic [15:0] head_i,
  output logic        has_pfx_o,
  output logic        am_o,
  output logic [1:0]  rsz_o,
  output logic [1:0]  ext_o,
  output logic        illegal_o,
  output logic [7:0]  opcode_o
);
  import pd_pkg::*;

  logic [7:0] first_b;
  logic [7:0] second_b;
  logic [7:0] ctrl_b;

  assign first_b   = head_i[7:0];
  assign second_b  = head_i[15:8];
  assign has_pfx_o = (first_b[2:0] == PFX_MARK);
  // absent prefix behaves as one with all control bits clear
  assign ctrl_b    = has_pfx_o ? first_b : 8'h00;
  assign opcode_o  = has_pfx_o ? second_b : first_b;
  assign am_o      = ctrl_b[PFX_AM_BIT];
  assign rsz_o     = ctrl_b[PFX_RSZ_LSB +: 2];
  assign ext_o     = ctrl_b[PFX_EXT_LSB +: 2];
  assign illegal_o = (ext_o == EXT_UNUSED);
endmodule

// File: rtl/pd_len_calc.sv
module pd_len_calc #(
  parameter int unsigned LEN_W = 4
) (
  input  logic             has_pfx_i,
  input  logic             am_i,
  input  logic [1:0]       rsz_i,
  input  pd_pkg::opr_class_e cls_i,
  output logic [LEN_W-1:0] opr_len_o,
  output logic [LEN_W-1:0] total_len_o
);
  import pd_pkg::*;

  always_comb begin
    unique case (cls_i)
      OPC_IMM:    opr_len_o = LEN_W'(1) << rsz_i;
      OPC_ADDR_S: opr_len_o = am_i ? LEN_W'(4) : LEN_W'(1);
      OPC_ADDR_L: opr_len_o = am_i ? LEN_W'(8) : LEN_W'(2);
      default:    opr_len_o = '0;
    endcase
  end

  assign total_len_o = opr_len_o + LEN_W'(1) + LEN_W'(has_pfx_i);
endmodule

// File: rtl/pd_operand_gather.sv
module pd_operand_gather #(
  parameter int unsigned OPR_BYTES = 8,
  parameter int unsigned WIN       = OPR_BYTES + 2,
  parameter int unsigned LEN_W     = 4
) (
  input  logic [8*WIN-1:0]       win_i,
  input  logic                   has_pfx_i,
  input  logic [LEN_W-1:0]       opr_len_i,
  output logic [8*OPR_BYTES-1:0] operand_o
);
  for (genvar i = 0; i < OPR_BYTES; i++) begin : g_byte
    localparam int unsigned NO_PFX = i + 1;
    localparam int unsigned W_PFX  = i + 2;
    logic [7:0] pick;
    assign pick = has_pfx_i ? win_i[8*W_PFX +: 8] : win_i[8*NO_PFX +: 8];
    assign operand_o[8*i +: 8] = (LEN_W'(i) < opr_len_i) ? pick : 8'h00;
  end
endmodule

// File: rtl/instr_prefix_decoder.sv
module instr_prefix_decoder #(
  parameter int unsigned OPR_BYTES = 8,
  localparam int unsigned WIN      = OPR_BYTES + 2,
  localparam int unsigned LEN_W    = $clog2(WIN + 1)
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [8*WIN-1:0]       win_bytes_i,
  input  logic [LEN_W-1:0]       win_avail_i,
  output logic                   win_consume_o,
  output logic [LEN_W-1:0]       win_consume_cnt_o,
  output logic [7:0]             lut_opcode_o,
  input  logic [1:0]             lut_class_i,
  output logic                   out_valid_o,
  input  logic                   out_ready_i,
  output logic                   out_am_o,
  output logic [1:0]             out_rsz_o,
  output logic [1:0]             out_ext_o,
  output logic                   out_illegal_o,
  output logic [7:0]             out_opcode_o,
  output logic [8*OPR_BYTES-1:0] out_operand_o,
  output logic [LEN_W-1:0]       out_len_o
);
  import pd_pkg::*;

  logic                   has_pfx;
  logic                   am;
  logic [1:0]             rsz;
  logic [1:0]             ext;
  logic                   illegal;
  logic [7:0]             opcode;
  logic [LEN_W-1:0]       opr_len;
  logic [LEN_W-1:0]       total_len;
  logic [8*OPR_BYTES-1:0] operand;
  logic                   slot_free;
  logic                   take;

  pd_prefix_split u_split (
    .head_i    (win_bytes_i[15:0]),
    .has_pfx_o (has_pfx),
    .am_o      (am),
    .rsz_o     (rsz),
    .ext_o     (ext),
    .illegal_o (illegal),
    .opcode_o  (opcode)
  );

  pd_len_calc #(.LEN_W(LEN_W)) u_len (
    .has_pfx_i   (has_pfx),
    .am_i        (am),
    .rsz_i       (rsz),
    .cls_i       (opr_class_e'(lut_class_i)),
    .opr_len_o   (opr_len),
    .total_len_o (total_len)
  );

  pd_operand_gather #(.OPR_BYTES(OPR_BYTES), .WIN(WIN), .LEN_W(LEN_W)) u_gather (
    .win_i     (win_bytes_i),
    .has_pfx_i (has_pfx),
    .opr_len_i (opr_len),
    .operand_o (operand)
  );

  assign lut_opcode_o      = opcode;
  // the output slot reloads in the cycle its current content leaves
  assign slot_free         = !out_valid_o || out_ready_i;
  assign take              = slot_free && (win_avail_i >= total_len);
  assign win_consume_o     = take;
  assign win_consume_cnt_o = take ? total_len : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid_o   <= 1'b0;
      out_am_o      <= 1'b0;
      out_rsz_o     <= '0;
      out_ext_o     <= '0;
      out_illegal_o <= 1'b0;
      out_opcode_o  <= '0;
      out_operand_o <= '0;
      out_len_o     <= '0;
    end else if (take) begin
      out_valid_o   <= 1'b1;
      out_am_o      <= am;
      out_rsz_o     <= rsz;
      out_ext_o     <= ext;
      out_illegal_o <= illegal;
      out_opcode_o  <= opcode;
      out_operand_o <= operand;
      out_len_o     <= total_len;
    end else if (out_ready_i) begin
      out_valid_o   <= 1'b0;
    end
  end
endmodule

// File: rtl/pd_checker.sv
module pd_checker #(
  parameter int unsigned OPR_BYTES = 8,
  parameter int unsigned LEN_W     = 4
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic [LEN_W-1:0]       win_avail_i,
  input logic                   win_consume_o,
  input logic [LEN_W-1:0]       win_consume_cnt_o,
  input logic                   out_valid_o,
  input logic                   out_ready_i,
  input logic [1:0]             out_ext_o,
  input logic                   out_illegal_o,
  input logic [7:0]             out_opcode_o,
  input logic [8*OPR_BYTES-1:0] out_operand_o,
  input logic [LEN_W-1:0]       out_len_o
);
  // R7: never take more bytes than the window holds
  p_take_fits_r7: assert property (@(posedge clk) disable iff (!rst_n)
    win_consume_o |-> (win_consume_cnt_o <= win_avail_i) && (win_consume_cnt_o != '0));

  // R8: a consume is followed by valid output with that length
  p_consume_then_valid_r8: assert property (@(posedge clk) disable iff (!rst_n)
    win_consume_o |=> out_valid_o && (out_len_o == $past(win_consume_cnt_o)));

  // R9: a stalled output blocks further consumption
  p_stall_no_take_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid_o && !out_ready_i) |-> !win_consume_o);

  // R9: a stalled output keeps its content
  p_stall_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid_o && !out_ready_i) |=> out_valid_o && $stable(out_operand_o)
      && $stable(out_opcode_o) && $stable(out_len_o));

  // R10: illegal flag tracks the unused extension code
  p_illegal_ext_r10: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid_o |-> (out_illegal_o == (out_ext_o == 2'b10)));

  // R5: reported length stays within 1 .. OPR_BYTES+2
  p_len_range_r5: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid_o |-> (out_len_o >= LEN_W'(1)) && (out_len_o <= LEN_W'(OPR_BYTES + 2)));
endmodule

bind instr_prefix_decoder pd_checker #(.OPR_BYTES(OPR_BYTES), .LEN_W(LEN_W)) u_pd_checker (
  .clk               (clk),
  .rst_n             (rst_n),
  .win_avail_i       (win_avail_i),
  .win_consume_o     (win_consume_o),
  .win_consume_cnt_o (win_consume_cnt_o),
  .out_valid_o       (out_valid_o),
  .out_ready_i       (out_ready_i),
  .out_ext_o         (out_ext_o),
  .out_illegal_o     (out_illegal_o),
  .out_opcode_o      (out_opcode_o),
  .out_operand_o     (out_operand_o),
  .out_len_o         (out_len_o)
);

// File: tb/test_instr_prefix_decoder.sv
`timescale 1ns/1ps
module test_instr_prefix_decoder;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [79:0] win_bytes;
  logic [3:0]  win_avail = '0;
  logic        consume;
  logic [3:0]  consume_cnt;
  logic [7:0]  lut_opcode;
  logic [1:0]  lut_class;
  logic        out_valid;
  logic        out_ready = 1'b1;
  logic        out_am;
  logic [1:0]  out_rsz;
  logic [1:0]  out_ext;
  logic        out_illegal;
  logic [7:0]  out_opcode;
  logic [63:0] out_operand;
  logic [3:0]  out_len;
  logic [7:0]  b [10];

  int checks = 0;
  int fails  = 0;
  int cycles = 0;

  always #10 clk = ~clk;

  always_comb
    for (int i = 0; i < 10; i++) win_bytes[8*i +: 8] = b[i];

  // bench operand-class table: class is the low two opcode bits
  assign lut_class = lut_opcode[1:0];

  instr_prefix_decoder i_instr_prefix_decoder (
    .clk               (clk),
    .rst_n             (rst_n),
    .win_bytes_i       (win_bytes),
    .win_avail_i       (win_avail),
    .win_consume_o     (consume),
    .win_consume_cnt_o (consume_cnt),
    .lut_opcode_o      (lut_opcode),
    .lut_class_i       (lut_class),
    .out_valid_o       (out_valid),
    .out_ready_i       (out_ready),
    .out_am_o          (out_am),
    .out_rsz_o         (out_rsz),
    .out_ext_o         (out_ext),
    .out_illegal_o     (out_illegal),
    .out_opcode_o      (out_opcode),
    .out_operand_o     (out_operand),
    .out_len_o         (out_len)
  );

  task automatic chk(input string req, input string what, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // present the window, check the accepting cycle, then the registered result
  task automatic decode_one(input string req, input logic [3:0] avail, input logic [7:0] e_op,
                            input logic [3:0] e_len, input logic [63:0] e_opr, input logic e_am,
                            input logic [1:0] e_rsz, input logic [1:0] e_ext, input logic e_ill);
    @(negedge clk);
    out_ready = 1'b1;
    win_avail = avail;
    #2;
    chk("R11", {req, " lookup opcode"}, 64'(lut_opcode), 64'(e_op));
    chk("R8", {req, " consume"}, 64'(consume), 64'd1);
    chk("R5", {req, " consume count"}, 64'(consume_cnt), 64'(e_len));
    @(negedge clk);
    win_avail = '0;
    chk("R8", {req, " valid"}, 64'(out_valid), 64'd1);
    chk("R5", {req, " length"}, 64'(out_len), 64'(e_len));
    chk(req, "opcode", 64'(out_opcode), 64'(e_op));
    chk("R6", {req, " operand"}, out_operand, e_opr);
    chk("R2", {req, " am"}, 64'(out_am), 64'(e_am));
    chk("R2", {req, " rsz"}, 64'(out_rsz), 64'(e_rsz));
    chk("R2", {req, " ext"}, 64'(out_ext), 64'(e_ext));
    chk("R10", {req, " illegal"}, 64'(out_illegal), 64'(e_ill));
    @(negedge clk);
  endtask

  task automatic t_reset();
    #2;
    chk("R1", "valid in reset", 64'(out_valid), 64'd0);
    chk("R1", "consume in reset", 64'(consume), 64'd0);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1", "valid after reset", 64'(out_valid), 64'd0);
  endtask

  task automatic t_no_prefix();
    b = '{8'h08, 8'hEE, 8'hEE, 8'hEE, 8'hEE, 8'hEE, 8'hEE, 8'hEE, 8'hEE, 8'hEE};
    decode_one("R3", 4'd10, 8'h08, 4'd1, 64'h0, 1'b0, 2'b00, 2'b00, 1'b0);
    b = '{8'h01, 8'hAB, 8'hEE, 8'hEE, 8'hEE, 8'hEE, 8'hEE, 8'hEE, 8'hEE, 8'hEE};
    decode_one("R3", 4'd10, 8'h01, 4'd2, 64'hAB, 1'b0, 2'b00, 2'b00, 1'b0);
  endtask

  task automatic t_immediates();
    // R4 immediate 64-bit with prefix: full ten-byte instruction
    b = '{8'h37, 8'h09, 8'h11, 8'h22, 8'h33, 8'h44, 8'h55, 8'h66, 8'h77, 8'h88};
    decode_one("R4", 4'd10, 8'h09, 4'd10, 64'h8877665544332211, 1'b0, 2'b11, 2'b00, 1'b0);
    // R4 immediate 16-bit
    b = '{8'h17, 8'h05, 8'hCD, 8'hAB, 8'hEE, 8'hEE, 8'hEE, 8'hEE, 8'hEE, 8'hEE};
    decode_one("R4", 4'd10, 8'h05, 4'd4, 64'hABCD, 1'b0, 2'b01, 2'b00, 1'b0);
  endtask

  task automatic t_addresses();
    b = '{8'h0F, 8'h12, 8'hA1, 8'hB2, 8'hC3, 8'hD4, 8'hEE, 8'hEE, 8'hEE, 8'hEE};
    decode_one("R4", 4'd10, 8'h12, 4'd6, 64'hD4C3B2A1, 1'b1, 2'b00, 2'b00, 1'b0);
    b = '{8'h0F, 8'h13, 8'h01, 8'h02, 8'h03, 8'h04, 8'h05, 8'h06, 8'h07, 8'h08};
    decode_one("R4", 4'd10, 8'h13, 4'd10, 64'h0807060504030201, 1'b1, 2'b00, 2'b00, 1'b0);
    b = '{8'h13, 8'h34, 8'h12, 8'hEE, 8'hEE, 8'hEE, 8'hEE, 8'hEE, 8'hEE, 8'hEE};
    decode_one("R4", 4'd10, 8'h13, 4'd3, 64'h1234, 1'b0, 2'b00, 2'b00, 1'b0);
    b = '{8'h12, 8'h7F, 8'hEE, 8'hEE, 8'hEE, 8'hEE, 8'hEE, 8'hEE, 8'hEE, 8'hEE};
    decode_one("R4", 4'd10, 8'h12, 4'd2, 64'h7F, 1'b0, 2'b00, 2'b00, 1'b0);
  endtask

  task automatic t_extensions();
    b = '{8'h87, 8'h00, 8'hEE, 8'hEE, 8'hEE, 8'hEE, 8'hEE, 8'hEE, 8'hEE, 8'hEE};
    decode_one("R10", 4'd10, 8'h00, 4'd2, 64'h0, 1'b0, 2'b00, 2'b10, 1'b1);
    b = '{8'hC7, 8'h04, 8'hEE, 8'hEE, 8'hEE, 8'hEE, 8'hEE, 8'hEE, 8'hEE, 8'hEE};
    decode_one("R10", 4'd10, 8'h04, 4'd2, 64'h0, 1'b0, 2'b00, 2'b11, 1'b0);
  endtask

  task automatic t_prefix_like_opcode();
    // R2 second byte with low bits 111 is still the opcode
    b = '{8'h07, 8'h0F, 8'h22, 8'h11, 8'hEE, 8'hEE, 8'hEE, 8'hEE, 8'hEE, 8'hEE};
    decode_one("R2", 4'd10, 8'h0F, 4'd4, 64'h1122, 1'b0, 2'b00, 2'b00, 1'b0);
  endtask

  task automatic t_short_window();
    b = '{8'h37, 8'h09, 8'h11, 8'h22, 8'h33, 8'h44, 8'h55, 8'h66, 8'h77, 8'h88};
    @(negedge clk);
    win_avail = 4'd9;
    #2;
    chk("R7", "consume with 9 of 10 bytes", 64'(consume), 64'd0);
    @(negedge clk);
    chk("R7", "valid with 9 of 10 bytes", 64'(out_valid), 64'd0);
    chk("R7", "consume still held", 64'(consume), 64'd0);
    decode_one("R7", 4'd10, 8'h09, 4'd10, 64'h8877665544332211, 1'b0, 2'b11, 2'b00, 1'b0);
  endtask

  task automatic t_backpressure();
    b = '{8'h08, 8'hEE, 8'hEE, 8'hEE, 8'hEE, 8'hEE, 8'hEE, 8'hEE, 8'hEE, 8'hEE};
    @(negedge clk);
    out_ready = 1'b0;
    win_avail = 4'd1;
    @(negedge clk);
    b = '{8'h01, 8'h5A, 8'hEE, 8'hEE, 8'hEE, 8'hEE, 8'hEE, 8'hEE, 8'hEE, 8'hEE};
    win_avail = 4'd2;
    #2;
    chk("R9", "consume while stalled", 64'(consume), 64'd0);
    chk("R9", "valid while stalled", 64'(out_valid), 64'd1);
    @(negedge clk);
    chk("R9", "consume still stalled", 64'(consume), 64'd0);
    chk("R9", "held opcode", 64'(out_opcode), 64'h08);
    chk("R9", "held length", 64'(out_len), 64'd1);
    out_ready = 1'b1;
    #2;
    chk("R9", "consume on release", 64'(consume), 64'd1);
    chk("R9", "count on release", 64'(consume_cnt), 64'd2);
    @(negedge clk);
    win_avail = '0;
    chk("R9", "next opcode", 64'(out_opcode), 64'h01);
    chk("R9", "next operand", out_operand, 64'h5A);
    chk("R9", "next valid", 64'(out_valid), 64'd1);
    @(negedge clk);
    chk("R8", "valid drops when drained", 64'(out_valid), 64'd0);
  endtask

  initial begin
    b = '{8'h08, 8'hEE, 8'hEE, 8'hEE, 8'hEE, 8'hEE, 8'hEE, 8'hEE, 8'hEE, 8'hEE};
    t_reset();
    t_no_prefix();
    t_immediates();
    t_addresses();
    t_extensions();
    t_prefix_like_opcode();
    t_short_window();
    t_backpressure();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000) begin
      checks++;
      fails++;
      $display("FAIL watchdog (all requirements): actual %0d cycles expected fewer than 20000", cycles);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule